// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences an 8-bit successive-approximation conversion for a microcontroller-style analog peripheral. Software asks for a conversion by writing a one to the run request bit (`go_set`). The block stops the sample-and-hold from tracking. It then lines up with the last quarter of the current instruction cycle, and in RC mode it waits one extra instruction cycle. After that it runs the conversion clock and settles one result bit per conversion-clock period, starting at the most significant bit.

The trial code is driven to the DAC on `dac_code`. At the end of each period the comparator answer `cmp_ge` decides whether the trial bit stays set. When the last bit is settled, the block loads the result register, raises the interrupt flag and drops `go`, all on the same clock edge. The sample-and-hold returns to tracking one and a half conversion-clock periods later.

The conversion clock comes from one of two sources:
- **Divider:** a divider on the system clock, with a period of 2, 8 or 32 system clocks.
- **RC:** an external RC oscillator tick, where each `rc_tick` pulse marks one half period.

Software may abandon a conversion by clearing the run bit (`go_clr`).

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `go`=0, `int_flag`=0, `result`=0, `adc_clk_run`=0 and `sampling`=1.
- R2: A `go_set` pulse while idle (`go`=0, `sampling`=1) makes `go`=1 and `sampling`=0 on the next clock edge.
- R3: With `clk_sel`=0, `adc_clk_run` is high in the cycle right after the first cycle with `phase`=3 (the fourth quarter) seen once `go` is set, and `adc_clk_run` is never high while `go` is low.
- R4: With `clk_sel`=1, `adc_clk_run` stays low for 4 more cycles (one instruction cycle) after that point, and rises in the fifth cycle after the `phase`=3 cycle.
- R5: With the divider source, the conversion-clock period D is 2, 8 or 32 clocks for `div_sel` = 0, 1 or 2. `int_flag` rises exactly 8·D cycles after `adc_clk_run` rises.
- R6: Bits are tried from bit 7 down to bit 0. When `adc_clk_run` rises, `dac_code` is 8'h80. At the end of each period a bit is kept when `cmp_ge`=1 (input ≥ DAC level) and cleared otherwise, so `result` equals the input code.
- R7: `result` keeps its previous value for the whole conversion and changes only on the edge where `go` falls at completion.
- R8: On completion, `int_flag` goes to 1 and `go` goes to 0 on the same edge, and `adc_clk_run` drops.
- R9: `sampling` stays 0 while the conversion clock runs. It returns to 1 exactly 3·D/2 cycles after `int_flag` rises.
- R10: A `go_clr` pulse during a conversion makes, on the next edge, `go`=0 and `sampling`=1. `result` is unchanged and `int_flag` stays 0.
- R11: A `go_set` pulse while a conversion runs neither restarts it nor shifts its timing.
- R12: An `int_clr` pulse clears `int_flag` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 2 | Quarter of the instruction cycle, 3 = last quarter |
| clk_sel | input | 1 | Conversion clock source: 0 divider, 1 RC |
| div_sel | input | 2 | Divider choice: 0 → 2, 1 → 8, 2/3 → 32 clocks |
| rc_tick | input | 1 | RC oscillator half-period pulse |
| go_set | input | 1 | Software write setting the run bit |
| go_clr | input | 1 | Software write clearing the run bit (abort) |
| int_clr | input | 1 | Software clear of the interrupt flag |
| cmp_ge | input | 1 | Comparator: analog input ≥ DAC level |
| go | output | 1 | Run bit, readable by software |
| adc_clk_run | output | 1 | Conversion clock active |
| sampling | output | 1 | Sample-and-hold tracking the input |
| dac_code | output | 8 | Trial code driven to the DAC |
| result | output | 8 | Conversion result register |
| int_flag | output | 1 | Conversion-done interrupt flag |

## Verification
The bench aims at these corner cases:
- **Start alignment in both clock modes.** A block that starts on the wrong quarter, or that skips the extra RC instruction cycle, puts the `adc_clk_run` edge in the wrong cycle.
- **Extreme input codes 0x00 and 0xFF.** They catch an off-by-one in the bit walk or an inverted keep rule, and 0x80 checks the MSB-only case.
- **Result hold.** Comparing `result` with the old value in every cycle of a conversion shows a register that leaks partial codes.
- **Abort and repeated start.** An abort that still loads the result or flags an interrupt is caught, and so is a second start that re-arms the sequence and so stretches the completion time.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_RCWAIT,
    ST_CONV,
    ST_RECOV
  } seq_state_t;

  localparam logic [1:0] PH_LAST = 2'd3;
endpackage

// File: rtl/sar_tad_gen.sv
`timescale 1ns/1ps
// Half-period tick source for the conversion clock.
module sar_tad_gen #(
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32,
  localparam int CW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       rc_mode,
  input  logic [1:0] div_sel,
  input  logic       rc_tick,
  output logic       half_tick
);
  logic [CW-1:0] half_len;
  logic [CW-1:0] cnt;
  logic          cnt_wrap;

  always_comb begin
    case (div_sel)
      2'd0:    half_len = CW'(DIV_FAST / 2);
      2'd1:    half_len = CW'(DIV_MID / 2);
      default: half_len = CW'(DIV_SLOW / 2);
    endcase
  end

  assign cnt_wrap = (cnt == half_len - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || rc_mode) begin
      cnt <= '0;
    end else if (cnt_wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign half_tick = run && (rc_mode ? rc_tick : cnt_wrap);
endmodule

// File: rtl/sar_bit_engine.sv
`timescale 1ns/1ps
// Successive-approximation register: trial bit walk from MSB to LSB.
module sar_bit_engine #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         decide,
  input  logic         cmp_ge,
  output logic [W-1:0] code,
  output logic [W-1:0] settled,
  output logic         last
);
  logic [IW-1:0] idx;
  logic [W-1:0]  nxt;

  always_comb begin
    settled = code;
    if (!cmp_ge) settled[idx] = 1'b0;
    nxt = settled;
    if (idx != '0) nxt[idx - IW'(1)] = 1'b1;
  end

  assign last = (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      idx  <= '0;
    end else if (load) begin
      code <= {1'b1, {(W-1){1'b0}}};
      idx  <= IW'(W - 1);
    end else if (decide) begin
      code <= nxt;
      if (idx != '0) idx <= idx - IW'(1);
    end
  end
endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int W          = 8,
  parameter int DIV_FAST   = 2,
  parameter int DIV_MID    = 8,
  parameter int DIV_SLOW   = 32,
  parameter int INSTR_CLKS = 4,
  parameter int REC_HALVES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   phase,
  input  logic         clk_sel,
  input  logic [1:0]   div_sel,
  input  logic         rc_tick,
  input  logic         go_set,
  input  logic         go_clr,
  input  logic         int_clr,
  input  logic         cmp_ge,
  output logic         go,
  output logic         adc_clk_run,
  output logic         sampling,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] result,
  output logic         int_flag
);
  localparam int WCW = (INSTR_CLKS > 2) ? $clog2(INSTR_CLKS) : 1;
  localparam int RCW = $clog2(REC_HALVES + 1);

  seq_state_t     state;
  logic           rc_q;
  logic           hphase;
  logic [WCW-1:0] wcnt;
  logic [RCW-1:0] rcnt;
  logic           half_tick;
  logic           abort;
  logic           enter_conv;
  logic           decide;
  logic           last;
  logic [W-1:0]   settled;

  always_comb begin
    abort = go_clr && (state == ST_SYNC || state == ST_RCWAIT || state == ST_CONV);
    enter_conv = !abort &&
      ((state == ST_SYNC && phase == PH_LAST && !rc_q) ||
       (state == ST_RCWAIT && wcnt == WCW'(INSTR_CLKS - 1)));
    decide = !abort && state == ST_CONV && half_tick && hphase;
  end

  sar_tad_gen #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) tad_i (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_CONV || state == ST_RECOV),
    .rc_mode  (rc_q),
    .div_sel  (div_sel),
    .rc_tick  (rc_tick),
    .half_tick(half_tick)
  );

  sar_bit_engine #(.W(W)) bits_i (
    .clk    (clk),
    .rst    (rst),
    .load   (enter_conv),
    .decide (decide),
    .cmp_ge (cmp_ge),
    .code   (dac_code),
    .settled(settled),
    .last   (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      go          <= 1'b0;
      int_flag    <= 1'b0;
      result      <= '0;
      sampling    <= 1'b1;
      adc_clk_run <= 1'b0;
      rc_q        <= 1'b0;
      hphase      <= 1'b0;
      wcnt        <= '0;
      rcnt        <= '0;
    end else begin
      if (int_clr) int_flag <= 1'b0;
      if (abort) begin
        go          <= 1'b0;
        sampling    <= 1'b1;
        adc_clk_run <= 1'b0;
        state       <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (go_set) begin
            go       <= 1'b1;
            sampling <= 1'b0;
            rc_q     <= clk_sel;
            state    <= ST_SYNC;
          end
          ST_SYNC: if (phase == PH_LAST) begin
            wcnt   <= '0;
            hphase <= 1'b0;
            if (rc_q) begin
              state <= ST_RCWAIT;
            end else begin
              state       <= ST_CONV;
              adc_clk_run <= 1'b1;
            end
          end
          ST_RCWAIT: begin
            if (enter_conv) begin
              state       <= ST_CONV;
              adc_clk_run <= 1'b1;
            end else begin
              wcnt <= wcnt + WCW'(1);
            end
          end
          ST_CONV: if (half_tick) begin
            hphase <= !hphase;
            if (hphase && last) begin
              result      <= settled;
              int_flag    <= 1'b1;
              go          <= 1'b0;
              adc_clk_run <= 1'b0;
              rcnt        <= '0;
              state       <= ST_RECOV;
            end
          end
          ST_RECOV: if (half_tick) begin
            if (rcnt == RCW'(REC_HALVES - 1)) begin
              sampling <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              rcnt <= rcnt + RCW'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_conv_seq_chk.sv
`timescale 1ns/1ps
module sar_conv_seq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         go_set,
  input logic         go,
  input logic         adc_clk_run,
  input logic         sampling,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] result,
  input logic         int_flag
);
  AST_GO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!go && sampling && go_set) |=> (go && !sampling)); // R2

  AST_CLK_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
    adc_clk_run |-> go); // R3

  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_clk_run) |-> (dac_code == {1'b1, {(W-1){1'b0}}})); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(go) |-> $stable(result)); // R7

  AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (rst)
    $rose(int_flag) |-> ($fell(go) && !adc_clk_run)); // R8

  AST_NO_SAMPLE_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    sampling |-> !adc_clk_run); // R9
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .go_set     (go_set),
  .go         (go),
  .adc_clk_run(adc_clk_run),
  .sampling   (sampling),
  .dac_code   (dac_code),
  .result     (result),
  .int_flag   (int_flag)
);

// File: tb/sar_conv_seq_tb_top.sv
`timescale 1ns/1ps
module sar_conv_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ph;
  logic       clk_sel = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       rc_tick;
  logic [1:0] rc_cnt;
  logic       go_set = 1'b0;
  logic       go_clr = 1'b0;
  logic       int_clr = 1'b0;
  logic [7:0] vin = 8'h00;
  logic       cmp_ge;
  logic       go, adc_clk_run, sampling, int_flag;
  logic [7:0] dac_code, result;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= 2'd0; rc_cnt <= 2'd0; rc_tick <= 1'b0;
    end else begin
      ph <= ph + 2'd1;
      rc_cnt <= (rc_cnt == 2'd2) ? 2'd0 : rc_cnt + 2'd1;
      rc_tick <= (rc_cnt == 2'd2);
    end
  end

  assign cmp_ge = (vin >= dac_code);

  sar_conv_seq dut_i (
    .clk(clk), .rst(rst), .phase(ph), .clk_sel(clk_sel), .div_sel(div_sel),
    .rc_tick(rc_tick), .go_set(go_set), .go_clr(go_clr), .int_clr(int_clr),
    .cmp_ge(cmp_ge), .go(go), .adc_clk_run(adc_clk_run), .sampling(sampling),
    .dac_code(dac_code), .result(result), .int_flag(int_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] d);
    return (d == 2'd0) ? 2 : (d == 2'd1) ? 8 : 32;
  endfunction

  task automatic pulse_go();
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Full conversion with start alignment, timing and result checks.
  task automatic t_conv(input logic [7:0] v, input logic [1:0] d, input bit rc,
                        input bit extra_go);
    logic [7:0] old;
    int n;
    int dv;
    dv = div_of(d);
    vin = v; div_sel = d; clk_sel = rc;
    old = result;
    @(negedge clk);
    pulse_go();
    chk(go == 1'b1 && sampling == 1'b0, "R2 go set / sampling stop", go, 1);
    n = 0;
    while (ph != 2'd3 && n < 8) begin
      @(negedge clk); n++;
    end
    chk(adc_clk_run == 1'b0, "R3 clock idle before Q4 edge", adc_clk_run, 0);
    if (!rc) begin
      @(negedge clk);
      chk(adc_clk_run == 1'b1, "R3 clock starts after Q4", adc_clk_run, 1);
    end else begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(adc_clk_run == 1'b0, "R4 RC extra instruction cycle", adc_clk_run, 0);
      end
      @(negedge clk);
      chk(adc_clk_run == 1'b1, "R4 RC clock starts", adc_clk_run, 1);
    end
    chk(dac_code == 8'h80, "R6 first trial is MSB", dac_code, 8'h80);
    n = 0;
    while (!int_flag && n < 20000) begin
      if (result != old) chk(0, "R7 result held during conversion", result, old);
      if (extra_go && n == 3) go_set = 1'b1;
      if (extra_go && n == 4) go_set = 1'b0;
      @(negedge clk); n++;
    end
    go_set = 1'b0;
    if (!rc)
      chk(n == 8 * dv, extra_go ? "R11 restart ignored, timing kept" : "R5 conversion length",
          n, 8 * dv);
    chk(go == 1'b0 && adc_clk_run == 1'b0, "R8 done clears go", go, 0);
    chk(result == v, "R6 result equals input", result, v);
    n = 0;
    while (!sampling && n < 20000) begin
      @(negedge clk); n++;
    end
    if (!rc) chk(n == 3 * dv / 2, "R9 return to sampling delay", n, 3 * dv / 2);
    else chk(sampling == 1'b1, "R9 sampling resumes (RC)", sampling, 1);
    int_clr = 1'b1;
    @(negedge clk);
    int_clr = 1'b0;
    chk(int_flag == 1'b0, "R12 flag clear", int_flag, 0);
  endtask

  task automatic t_abort();
    logic [7:0] old;
    old = result;
    vin = 8'h5A; div_sel = 2'd1; clk_sel = 1'b0;
    @(negedge clk);
    pulse_go();
    while (!adc_clk_run) @(negedge clk);
    repeat (20) @(negedge clk);
    go_clr = 1'b1;
    @(negedge clk);
    go_clr = 1'b0;
    chk(go == 1'b0 && sampling == 1'b1, "R10 abort clears go, resumes sampling", go, 0);
    repeat (100) @(negedge clk);
    chk(result == old, "R10 abort keeps result", result, old);
    chk(int_flag == 1'b0, "R10 abort sets no flag", int_flag, 0);
    chk(adc_clk_run == 1'b0, "R10 abort stops clock", adc_clk_run, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(go == 0 && int_flag == 0 && adc_clk_run == 0, "R1 reset outputs", go, 0);
    chk(result == 8'h00 && sampling == 1'b1, "R1 reset result/sampling", result, 0);
    t_conv(8'h00, 2'd0, 1'b0, 1'b0);
    t_conv(8'hFF, 2'd1, 1'b0, 1'b0);
    t_conv(8'hA5, 2'd2, 1'b0, 1'b0);
    t_conv(8'h3C, 2'd0, 1'b1, 1'b0);
    t_conv(8'h80, 2'd0, 1'b0, 1'b0);
    t_abort();
    t_conv(8'h17, 2'd1, 1'b0, 1'b1);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule